// File: doc/BRIEF.md
# I2C Byte-Level Master Engine

This block is a single-master I2C engine that software steps one bus event at a time. A small register file holds a data byte, a control byte, a status byte and a clock-control byte. Software writes the control byte to ask for a START, an address or data byte, or a STOP. The engine carries out that one step on the open-drain SCL and SDA lines and raises its flag (also driven out as an interrupt). It then holds the bus until software clears the flag with the next control write.

Every completed step leaves an 8-bit status code that tells software what happened: which condition was sent, whether the byte was acknowledged, whether a received byte was answered with ACK or NACK, or whether arbitration was lost. The SCL rate comes from the system clock through a mantissa/exponent divider. Slave operation and 10-bit addressing are not part of this block.

Top module: `i2c_byte_master`

## Requirements
- R1: Register addresses are 0 data, 1 control, 2 status (read-only), 3 clock control. After reset the status reads 0xF8, control reads 0x00, the flag is low and neither line is driven low.
- R2: Writing control with enable (bit 6) and START (bit 5) on a free bus makes SDA fall while SCL is high, then SCL is held low. The flag (control bit 3, output `irq_o`) sets, status becomes 0x08 and the START bit clears.
- R3: The first byte after a START is the data register (7-bit address shifted left, LSB 1 for read), sent MSB first. An ACK gives status 0x18 for write or 0x40 for read. A NACK gives 0x20 or 0x48.
- R4: A later byte in write direction is sent MSB first and gives status 0x28 on ACK and 0x30 on NACK.
- R5: After an acknowledged read address, each step shifts in 8 bits MSB first into the data register. With assert-acknowledge (bit 2) set the master drives ACK in the ninth bit and reports 0x50. With it clear the master leaves NACK and reports 0x58.
- R6: A START request while this master still holds the bus produces a repeated START with status 0x10.
- R7: A STOP request (bit 4) makes SDA rise while SCL is high and leaves both lines released. Status becomes 0xF8, the flag stays clear and the STOP bit clears.
- R8: If SDA reads low while the master drives a 1 in an address or data bit, the master releases both lines at once, sets the flag and reports 0x38. The next START is a fresh START (0x08).
- R9: The SCL period is 20·(M+1)·(THP+1)·2^N system clocks, with M in clock-control bits [6:3], N in bits [2:0] and THP a parameter (default 24).
- R10: Writing control with enable clear releases both lines at once and forces status 0xF8. START requests written while enable is clear have no effect on the bus.
- R11: While the flag is set the bus lines do not change. The next step starts only after control is written with bit 3 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| irq_o | output | 1 | Step-complete flag |
| scl_drive_lo | output | 1 | Pull SCL low when high |
| sda_drive_lo | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A behavioural slave on the wired-AND lines is used with three patterns. The first is a write frame with an acknowledged address and data bytes, one of them refused. The second is a repeated-START read that ends with ACK then NACK from the master. The third is a frame whose address or write is refused. Together these separate every status code and show that the ninth bit carries the direction the requirements give. A second master pulling SDA low during an all-ones address tells arbitration loss apart from a plain NACK. Timing the SCL period at two divider settings checks that M and N scale it. A disable during a held bus shows the release path and that a START written while disabled is ignored.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   localparam logic [1:0] RA_DATA = 2'd0;
   localparam logic [1:0] RA_CTL  = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;
   localparam logic [1:0] RA_CLK  = 2'd3;

   localparam int CTL_AAK   = 2;
   localparam int CTL_IFLG  = 3;
   localparam int CTL_STP   = 4;
   localparam int CTL_STA   = 5;
   localparam int CTL_ENAB  = 6;
   localparam int CTL_CLKEN = 7;

   localparam logic [7:0] SC_START  = 8'h08;
   localparam logic [7:0] SC_RSTART = 8'h10;
   localparam logic [7:0] SC_AW_ACK = 8'h18;
   localparam logic [7:0] SC_AW_NAK = 8'h20;
   localparam logic [7:0] SC_DW_ACK = 8'h28;
   localparam logic [7:0] SC_DW_NAK = 8'h30;
   localparam logic [7:0] SC_ARB    = 8'h38;
   localparam logic [7:0] SC_AR_ACK = 8'h40;
   localparam logic [7:0] SC_AR_NAK = 8'h48;
   localparam logic [7:0] SC_DR_ACK = 8'h50;
   localparam logic [7:0] SC_DR_NAK = 8'h58;
   localparam logic [7:0] SC_IDLE   = 8'hF8;

   typedef enum logic [1:0] {BC_START, BC_STOP, BC_BIT} bitcmd_e;
   typedef enum logic [2:0] {S_IDLE, S_HOLD, S_START, S_BYTE, S_STOP} mstate_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
   parameter int THP   = 24,
   parameter int CNT_W = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [3:0] m_div,
   input  logic [2:0] n_div,
   output logic       tick
);
   localparam int QBASE = 5 * (THP + 1);

   logic [CNT_W-1:0] base, limit, cnt;

   assign base  = CNT_W'((32'(m_div) + 32'd1) * 32'(QBASE));
   assign limit = base << n_div;
   assign tick  = run && (cnt == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/i2cm_bitseq.sv
module i2cm_bitseq
   import i2cm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    flush,
   input  logic    tick,
   input  logic    go,
   input  bitcmd_e cmd,
   input  logic    tx_bit,
   input  logic    arb_en,
   input  logic    sda_in,
   output logic    busy,
   output logic    done,
   output logic    rx_bit,
   output logic    arb_lost,
   output logic    scl_lo,
   output logic    sda_lo
);
   logic    sda_s;
   logic [1:0] phase;
   bitcmd_e cmd_q;
   logic    tx_q, arb_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], sda_in};
         end
         assign sda_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; done <= 1'b0; rx_bit <= 1'b0; arb_lost <= 1'b0;
         scl_lo <= 1'b0; sda_lo <= 1'b0; phase <= 2'd0;
         cmd_q <= BC_BIT; tx_q <= 1'b1; arb_q <= 1'b0;
      end else begin
         done     <= 1'b0;
         arb_lost <= 1'b0;
         if (flush) begin
            busy <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0; phase <= 2'd0;
         end else if (go && !busy) begin
            busy <= 1'b1; phase <= 2'd0;
            cmd_q <= cmd; tx_q <= tx_bit; arb_q <= arb_en;
         end else if (busy && tick) begin
            phase <= phase + 2'd1;
            unique case (cmd_q)
               BC_START: case (phase)
                  2'd0: sda_lo <= 1'b0;
                  2'd1: scl_lo <= 1'b0;
                  2'd2: sda_lo <= 1'b1;
                  default: scl_lo <= 1'b1;
               endcase
               BC_STOP: case (phase)
                  2'd0: sda_lo <= 1'b1;
                  2'd1: scl_lo <= 1'b0;
                  2'd2: sda_lo <= 1'b0;
                  default: ;
               endcase
               default: case (phase)
                  2'd0: sda_lo <= ~tx_q;
                  2'd1: scl_lo <= 1'b0;
                  2'd2: rx_bit <= sda_s;
                  default: scl_lo <= 1'b1;
               endcase
            endcase
            if (phase == 2'd3) begin
               busy <= 1'b0; done <= 1'b1;
            end
            if (cmd_q == BC_BIT && phase == 2'd2 && arb_q && tx_q && !sda_s) begin
               busy <= 1'b0; done <= 1'b1; arb_lost <= 1'b1;
               scl_lo <= 1'b0; sda_lo <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cm_pkg::*;
#(
   parameter int THP         = 24,
   parameter int CNT_W       = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq_o,
   output logic       scl_drive_lo,
   output logic       sda_drive_lo,
   input  logic       sda_in
);
   localparam int QMAX = 5 * 16 * (THP + 1) * 128;

   generate
      if (THP < 1) begin : g_bad_thp
         $error("THP must be at least 1");
      end
      if (CNT_W < $clog2(QMAX + 1)) begin : g_bad_cnt
         $error("CNT_W too small for the largest divider setting");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   mstate_e    state;
   logic       aak_q, iflg_q, stp_q, sta_q, enab_q, clken_q;
   logic [7:0] data_q, stat_q, shift_q;
   logic [3:0] m_q, bitcnt_q;
   logic [2:0] n_q;
   logic       kick_q, rx_mode_q, addr_ph_q, rstart_q, go_q;
   logic       ctl_wr, disable_wr, run, tick, bus_free;
   logic       seq_busy, seq_done, seq_rx, seq_arb;
   bitcmd_e    cmd;
   logic       tx_bit, arb_en;

   assign ctl_wr     = reg_wr && (reg_addr == RA_CTL);
   assign disable_wr = ctl_wr && !reg_wdata[CTL_ENAB];
   assign run        = (state == S_START) || (state == S_BYTE) || (state == S_STOP);
   assign bus_free   = (state == S_IDLE);
   assign irq_o      = iflg_q;

   always_comb begin
      cmd    = BC_BIT;
      tx_bit = 1'b1;
      arb_en = 1'b0;
      if (state == S_START)     cmd = BC_START;
      else if (state == S_STOP) cmd = BC_STOP;
      else if (bitcnt_q < 4'd8) begin
         tx_bit = rx_mode_q ? 1'b1 : shift_q[7];
         arb_en = !rx_mode_q;
      end else begin
         tx_bit = rx_mode_q ? !aak_q : 1'b1;
      end
   end

   always_comb begin
      unique case (reg_addr)
         RA_DATA: reg_rdata = data_q;
         RA_CTL:  reg_rdata = {clken_q, enab_q, sta_q, stp_q, iflg_q, aak_q, 2'b00};
         RA_STAT: reg_rdata = stat_q;
         default: reg_rdata = {1'b0, m_q, n_q};
      endcase
   end

   i2cm_tick #(.THP(THP), .CNT_W(CNT_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .m_div(m_q), .n_div(n_q), .tick(tick)
   );

   i2cm_bitseq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
      .clk(clk), .rst_n(rst_n), .flush(disable_wr), .tick(tick), .go(go_q),
      .cmd(cmd), .tx_bit(tx_bit), .arb_en(arb_en), .sda_in(sda_in),
      .busy(seq_busy), .done(seq_done), .rx_bit(seq_rx), .arb_lost(seq_arb),
      .scl_lo(scl_drive_lo), .sda_lo(sda_drive_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         {aak_q, iflg_q, stp_q, sta_q, enab_q, clken_q} <= '0;
         data_q <= '0; stat_q <= SC_IDLE; shift_q <= '0;
         m_q <= '0; n_q <= '0; bitcnt_q <= '0;
         kick_q <= 1'b0; rx_mode_q <= 1'b0; addr_ph_q <= 1'b0;
         rstart_q <= 1'b0; go_q <= 1'b0;
      end else begin
         go_q <= 1'b0;
         if (reg_wr && reg_addr == RA_DATA) data_q <= reg_wdata;
         if (reg_wr && reg_addr == RA_CLK)  {m_q, n_q} <= reg_wdata[6:0];
         if (ctl_wr) begin
            aak_q   <= reg_wdata[CTL_AAK];
            stp_q   <= reg_wdata[CTL_STP];
            sta_q   <= reg_wdata[CTL_STA];
            enab_q  <= reg_wdata[CTL_ENAB];
            clken_q <= reg_wdata[CTL_CLKEN];
            if (!reg_wdata[CTL_IFLG]) iflg_q <= 1'b0;
            kick_q  <= 1'b1;
         end
         if (disable_wr) begin
            state <= S_IDLE; stat_q <= SC_IDLE; rx_mode_q <= 1'b0; kick_q <= 1'b0;
         end else begin
            unique case (state)
               S_IDLE, S_HOLD: if (kick_q) begin
                  kick_q <= 1'b0;
                  if (enab_q && !iflg_q) begin
                     if (sta_q) begin
                        state <= S_START; rstart_q <= (state == S_HOLD); go_q <= 1'b1;
                     end else if (stp_q) begin
                        if (state == S_HOLD) begin
                           state <= S_STOP; go_q <= 1'b1;
                        end else stp_q <= 1'b0;
                     end else if (state == S_HOLD) begin
                        state <= S_BYTE; bitcnt_q <= '0; shift_q <= data_q; go_q <= 1'b1;
                     end
                  end
               end
               S_START: if (seq_done) begin
                  stat_q <= rstart_q ? SC_RSTART : SC_START;
                  state <= S_HOLD; addr_ph_q <= 1'b1; rx_mode_q <= 1'b0;
                  sta_q <= 1'b0; iflg_q <= 1'b1;
               end
               S_STOP: if (seq_done) begin
                  stat_q <= SC_IDLE; stp_q <= 1'b0; state <= S_IDLE; rx_mode_q <= 1'b0;
               end
               default: if (seq_done) begin
                  if (seq_arb) begin
                     stat_q <= SC_ARB; state <= S_IDLE; iflg_q <= 1'b1;
                     rx_mode_q <= 1'b0; addr_ph_q <= 1'b0;
                  end else if (bitcnt_q < 4'd8) begin
                     shift_q <= {shift_q[6:0], seq_rx};
                     bitcnt_q <= bitcnt_q + 4'd1;
                     go_q <= 1'b1;
                  end else begin
                     iflg_q <= 1'b1; state <= S_HOLD;
                     if (rx_mode_q) begin
                        data_q <= shift_q;
                        stat_q <= aak_q ? SC_DR_ACK : SC_DR_NAK;
                     end else if (addr_ph_q) begin
                        addr_ph_q <= 1'b0;
                        rx_mode_q <= data_q[0] && !seq_rx;
                        if (data_q[0]) stat_q <= seq_rx ? SC_AR_NAK : SC_AR_ACK;
                        else           stat_q <= seq_rx ? SC_AW_NAK : SC_AW_ACK;
                     end else begin
                        stat_q <= seq_rx ? SC_DW_NAK : SC_DW_ACK;
                     end
                  end
               end
            endcase
         end
      end
   end

   logic unused_busy;
   assign unused_busy = seq_busy;
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq,
   input logic       scl_lo,
   input logic       sda_lo,
   input logic [7:0] stat,
   input logic       enab,
   input logic       bus_free
);
   // R10
   disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enab |-> (stat == 8'hF8) && !scl_lo && !sda_lo);

   // R7
   free_bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_free |-> !scl_lo && !sda_lo);

   // R11
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(irq) && enab) |-> $stable(scl_lo) && $stable(sda_lo));

   // R2
   flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> stat inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h28, 8'h30,
                                  8'h38, 8'h40, 8'h48, 8'h50, 8'h58});

   // R8
   arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq) && stat == 8'h38) |-> !scl_lo && !sda_lo);
endmodule

bind i2c_byte_master i2cm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq_o), .scl_lo(scl_drive_lo),
   .sda_lo(sda_drive_lo), .stat(stat_q), .enab(enab_q), .bus_free(bus_free)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   wire  [7:0] reg_rdata;
   wire        irq, scl_lo_w, sda_lo_w;
   logic       s_sda_lo = 1'b0;
   logic       arb_pull = 1'b0;
   wire        scl_line = ~scl_lo_w;
   wire        sda_line = ~(sda_lo_w | s_sda_lo | arb_pull);

   i2c_byte_master u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq),
      .scl_drive_lo(scl_lo_w), .sda_drive_lo(sda_lo_w), .sda_in(sda_line)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   always @(posedge clk) cyc++;

   // behavioural slave on the wired-AND lines
   logic prev_scl = 1'b1, prev_sda = 1'b1;
   bit   in_frame = 0, is_addr = 0, rd_mode = 0, ack_addr = 1, ack_data = 1;
   logic m_ack = 1'b1;
   int   bitcnt = 0, starts = 0, stops = 0;
   logic [7:0] shreg = 8'h00, txb = 8'hFF;
   logic [7:0] rx_q[$];
   logic [7:0] tx_q[$];

   always @(scl_line or sda_line) begin
      if (prev_scl === 1'b1 && scl_line === 1'b1 && prev_sda === 1'b1 && sda_line === 1'b0) begin
         in_frame = 1; is_addr = 1; rd_mode = 0; bitcnt = 0; s_sda_lo = 1'b0; starts++;
      end else if (prev_scl === 1'b1 && scl_line === 1'b1 && prev_sda === 1'b0 && sda_line === 1'b1) begin
         if (in_frame) stops++;
         in_frame = 0; s_sda_lo = 1'b0;
      end else if (in_frame && prev_scl === 1'b0 && scl_line === 1'b1) begin
         if (bitcnt < 8) begin
            shreg = {shreg[6:0], sda_line};
            bitcnt++;
            if (bitcnt == 8 && !rd_mode) rx_q.push_back(shreg);
         end else if (bitcnt == 8) begin
            m_ack = sda_line; bitcnt = 9;
         end
      end else if (in_frame && prev_scl === 1'b1 && scl_line === 1'b0) begin
         if (bitcnt == 8) begin
            s_sda_lo = rd_mode ? 1'b0 : (is_addr ? ack_addr : ack_data);
         end else if (bitcnt == 9) begin
            bitcnt = 0;
            if (is_addr) begin
               rd_mode = shreg[0] && !m_ack; is_addr = 0;
            end else if (rd_mode && m_ack) rd_mode = 0;
            if (rd_mode) begin
               txb = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hFF;
               s_sda_lo = ~txb[7];
            end else s_sda_lo = 1'b0;
         end else if (rd_mode && bitcnt >= 1 && bitcnt <= 7) begin
            s_sda_lo = ~txb[7 - bitcnt];
         end
      end
      prev_scl = scl_line; prev_sda = sda_line;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wait_irq(input string req);
      int k = 0;
      while (irq !== 1'b1 && k < 40000) begin @(negedge clk); k++; end
      chk({req, " flag"}, {31'd0, irq}, 32'd1);
   endtask

   task automatic step(input string req, input logic [7:0] ctl, input logic [7:0] exp_code);
      logic [7:0] s;
      wr(2'd1, ctl);
      wait_irq(req);
      rd(2'd2, s);
      chk({req, " status"}, {24'd0, s}, {24'd0, exp_code});
   endtask

   task automatic pop_rx(input string req, input logic [7:0] exp);
      logic [7:0] v;
      v = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hxx;
      chk({req, " byte on bus"}, {24'd0, v}, {24'd0, exp});
   endtask

   task automatic period(input string req, input logic [7:0] addr_byte, input int exp);
      int t0;
      wr(2'd0, addr_byte);
      wr(2'd1, 8'h40);
      @(posedge scl_line); t0 = cyc;
      @(posedge scl_line);
      chk({req, " SCL period"}, 32'(cyc - t0), 32'(exp));
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      int s0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd2, v); chk("R1 status", {24'd0, v}, 32'hF8);
      rd(2'd1, v); chk("R1 control", {24'd0, v}, 32'h00);
      chk("R1 flag", {31'd0, irq}, 32'd0);
      chk("R1 lines", {30'd0, scl_line, sda_line}, 32'd3);

      wr(2'd3, 8'h00);
      wr(2'd1, 8'h40);
      // R2 start on free bus
      s0 = starts;
      step("R2", 8'h60, 8'h08);
      chk("R2 start seen", 32'(starts), 32'(s0 + 1));
      chk("R2 scl held", {31'd0, scl_line}, 32'd0);
      rd(2'd1, v); chk("R2 start bit cleared", {31'd0, v[5]}, 32'd0);
      // R11 bus frozen while flag set
      repeat (2000) @(negedge clk);
      chk("R11 scl still low", {31'd0, scl_line}, 32'd0);
      chk("R11 nothing sent", 32'(rx_q.size()), 32'd0);
      // R9 + R3 address write, default divider
      period("R9 M0 N0", 8'hA0, 500);
      wait_irq("R3");
      rd(2'd2, v); chk("R3 addr write ack", {24'd0, v}, 32'h18);
      pop_rx("R3", 8'hA0);
      // R4 data write ack / nack
      wr(2'd0, 8'h3C); step("R4 ack", 8'h40, 8'h28); pop_rx("R4", 8'h3C);
      ack_data = 0;
      wr(2'd0, 8'hC5); step("R4 nack", 8'h40, 8'h30); pop_rx("R4", 8'hC5);
      ack_data = 1;
      // R6 repeated start
      s0 = starts;
      step("R6", 8'h60, 8'h10);
      chk("R6 start seen", 32'(starts), 32'(s0 + 1));
      // R3 read address, R5 receive
      tx_q.push_back(8'h96); tx_q.push_back(8'h5A);
      wr(2'd0, 8'hA1); step("R3 addr read ack", 8'h40, 8'h40); pop_rx("R3", 8'hA1);
      step("R5 ack", 8'h44, 8'h50);
      rd(2'd0, v); chk("R5 data 1", {24'd0, v}, 32'h96);
      chk("R5 master ack", {31'd0, m_ack}, 32'd0);
      step("R5 nack", 8'h40, 8'h58);
      rd(2'd0, v); chk("R5 data 2", {24'd0, v}, 32'h5A);
      chk("R5 master nack", {31'd0, m_ack}, 32'd1);
      // R7 stop
      s0 = stops;
      wr(2'd1, 8'h50);
      repeat (3000) @(negedge clk);
      rd(2'd2, v); chk("R7 status", {24'd0, v}, 32'hF8);
      chk("R7 flag clear", {31'd0, irq}, 32'd0);
      chk("R7 lines", {30'd0, scl_line, sda_line}, 32'd3);
      chk("R7 stop seen", 32'(stops), 32'(s0 + 1));
      rd(2'd1, v); chk("R7 stop bit cleared", {24'd0, v}, 32'h40);
      // R3 address nack both directions
      ack_addr = 0;
      step("R3 start", 8'h60, 8'h08);
      wr(2'd0, 8'hA0); step("R3 addr write nack", 8'h40, 8'h20); pop_rx("R3", 8'hA0);
      step("R6 restart", 8'h60, 8'h10);
      wr(2'd0, 8'hA1); step("R3 addr read nack", 8'h40, 8'h48); pop_rx("R3", 8'hA1);
      ack_addr = 1;
      wr(2'd1, 8'h50); repeat (1000) @(negedge clk);
      // R8 arbitration loss
      step("R8 start", 8'h60, 8'h08);
      wr(2'd0, 8'hFF);
      arb_pull = 1'b1;
      step("R8 lost", 8'h40, 8'h38);
      chk("R8 scl released", {31'd0, scl_line}, 32'd1);
      chk("R8 sda released", {31'd0, sda_lo_w}, 32'd0);
      arb_pull = 1'b0;
      repeat (10) @(negedge clk);
      step("R8 fresh start", 8'h60, 8'h08);
      wr(2'd1, 8'h50); repeat (1000) @(negedge clk);
      // R10 disable while bus held
      step("R10 start", 8'h60, 8'h08);
      wr(2'd1, 8'h00);
      chk("R10 lines", {30'd0, scl_line, sda_line}, 32'd3);
      rd(2'd2, v); chk("R10 status", {24'd0, v}, 32'hF8);
      chk("R10 flag", {31'd0, irq}, 32'd0);
      s0 = starts;
      wr(2'd1, 8'h20);
      repeat (1000) @(negedge clk);
      chk("R10 start ignored", 32'(starts), 32'(s0));
      chk("R10 scl idle", {31'd0, scl_line}, 32'd1);
      chk("R10 no flag", {31'd0, irq}, 32'd0);
      // R9 divider M=1 N=1
      wr(2'd3, 8'h09);
      wr(2'd1, 8'h40);
      step("R9 start", 8'h60, 8'h08);
      period("R9 M1 N1", 8'hA0, 2000);
      wait_irq("R9");
      rd(2'd2, v); chk("R9 addr ack", {24'd0, v}, 32'h18);
      rd(2'd3, v); chk("R9 clock reg", {24'd0, v}, 32'h09);
      pop_rx("R9", 8'hA0);
      wr(2'd1, 8'h50); repeat (6000) @(negedge clk);
      rd(2'd2, v); chk("R9 stop status", {24'd0, v}, 32'hF8);
      summary();
      $finish;
   end
endmodule